// File: doc/BRIEF.md
# Latched Channel-Select Switch Controller

This block drives the switch-enable lines of an analog multiplexer bank from a simple write port of the kind a processor bus provides. A channel code and an enable bit are captured while the write strobe is low. They are held after the strobe rises, and they are decoded into one-hot switch drives. A separate active-low clear input empties the held state, and every switch then turns off. Because the enable bit is held with the code, a program can park the bank with all switches open. This lets several banks share one analog output line.

A build parameter picks between two layouts. The single-ended layout has eight channels selected by a 3-bit code. The differential layout has four channel pairs selected by the low two code bits, and the `a` and `b` lines of the chosen pair close together. When the selection moves from one closed channel to another, the controller first opens every switch for a programmable number of clock cycles. Only then does it close the new one, so two channels are never joined, even for a moment. The write and clear inputs come from another timing domain. They pass through a two-stage synchroniser, and the code and enable follow the same two stages, so they stay aligned with the strobe. A status port reports the held code and enable, plus a busy flag for the dead-time window.

Top module: `chsel_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it, every switch output is 0, `busy` is 0, and `stat_ch` and `stat_en` are 0.
- R2: While `wr_n` is held low, the held code and enable follow `addr` and `en`, and the switch outputs follow them without any further strobe.
- R3: After `wr_n` rises, the values present on the last low sample are kept. Later changes on `addr` or `en` while `wr_n` stays high change neither the switch outputs nor the status.
- R4: While `clr_n` is low, the held code and enable are forced to 0 whatever `wr_n`, `addr` and `en` do, and every switch output goes to 0.
- R5: After `clr_n` returns high, all switches stay open until a write loads an enable of 1.
- R6: A held enable of 0 opens every switch, whatever the held code is.
- R7: Single-ended layout (DIFF=0): with enable 1, code k (0 to 7) drives `sw_a` bit k alone, and `sw_b` stays 0.
- R8: Differential layout (DIFF=1): with enable 1, `addr[1:0]` = k drives bit k of both `sw_a` and `sw_b`, `addr[2]` has no effect, and `stat_ch` reports k.
- R9: A switch that is closed never hands over directly to a different one. Between two different closed selections the outputs are all 0 for at least DEAD cycles, and for exactly DEAD cycles when the new selection is stable before the gap starts.
- R10: `busy` is high for exactly DEAD consecutive cycles per gap, and in the cycle after any cycle with `busy` high all switch outputs are 0.
- R11: At most one bit of `sw_a` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low; low makes the hold transparent, rising edge freezes it |
| clr_n | input | 1 | Master clear, active low; empties the held code and enable |
| addr | input | SEL_W | Channel code |
| en | input | 1 | Enable bit captured with the code |
| sw_a | output | NCH | One-hot switch drives (the `a` side in the differential layout) |
| sw_b | output | NCH | `b` side drives in the differential layout, 0 otherwise |
| stat_ch | output | SEL_W | Held channel code (upper bit 0 in the differential layout) |
| stat_en | output | 1 | Held enable bit |
| busy | output | 1 | High during the all-off dead time |

## Verification
The bench targets the hand-over from one closed channel to a different one. A design without the gap would show two codes back to back with no zero between them, and a wrong counter would make the measured gap differ from DEAD. It also tests a clear applied while the strobe is held low: if the clear did not win, the code on the bus would be captured. It moves the code while the strobe is high: an edge-blind hold would follow it. It toggles the unused top code bit in the differential layout: a decoder that still used that bit would pick a non-existent pair. Randomised writes, transparent runs and clears are checked against a bench model of the held state.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  typedef enum logic {
    SEQ_LIVE = 1'b0,
    SEQ_GAP  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/ctl_sync.sv
// Two-stage synchroniser over a bus; reset loads an idle value.
module ctl_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= IDLE;
      q      <= IDLE;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/sel_latch.sv
// Level-transparent hold of code and enable; clear dominates.
module sel_latch #(
  parameter int SEL_W = 3,
  parameter int ABITS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n_s,
  input  logic             clr_n_s,
  input  logic [SEL_W-1:0] addr_s,
  input  logic             en_s,
  output logic [ABITS-1:0] hold_ch,
  output logic             hold_en
);
  generate
    if (ABITS < SEL_W) begin : g_drop
      wire unused_hi = ^addr_s[SEL_W-1:ABITS];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !clr_n_s) begin
      hold_ch <= '0;
      hold_en <= 1'b0;
    end else if (!wr_n_s) begin
      hold_ch <= addr_s[ABITS-1:0];
      hold_en <= en_s;
    end
  end
endmodule

// File: rtl/bbm_seq.sv
// Break-before-make sequencer: opens everything for DEAD cycles
// whenever a closed selection must give way to a different one.
module bbm_seq
  import chsel_pkg::*;
#(
  parameter int ABITS = 3,
  parameter int DEAD  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tgt_on,
  input  logic [ABITS-1:0] tgt_ch,
  output logic             cur_on,
  output logic [ABITS-1:0] cur_ch,
  output logic             busy
);
  localparam int CW = (DEAD < 1) ? 1 : $clog2(DEAD + 1);

  seq_state_e    st;
  logic [CW-1:0] cnt;
  logic          differs;

  assign differs = (tgt_on != cur_on) || (tgt_on && (tgt_ch != cur_ch));
  assign busy    = (st == SEQ_GAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SEQ_LIVE;
      cnt    <= '0;
      cur_on <= 1'b0;
      cur_ch <= '0;
    end else begin
      case (st)
        SEQ_LIVE: begin
          if (differs) begin
            if (cur_on) begin
              cur_on <= 1'b0;
              st     <= SEQ_GAP;
              cnt    <= CW'(DEAD);
            end else begin
              cur_on <= tgt_on;
              cur_ch <= tgt_ch;
            end
          end
        end
        SEQ_GAP: begin
          if (cnt <= CW'(1)) begin
            cur_on <= tgt_on;
            cur_ch <= tgt_ch;
            st     <= SEQ_LIVE;
            cnt    <= '0;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: st <= SEQ_LIVE;
      endcase
    end
  end
endmodule

// File: rtl/sw_decode.sv
// Registered one-hot decode; the b side mirrors a in the differential layout.
module sw_decode #(
  parameter int ABITS = 3,
  parameter int NCH   = 8,
  parameter bit DIFF  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cur_on,
  input  logic [ABITS-1:0] cur_ch,
  output logic [NCH-1:0]   sw_a,
  output logic [NCH-1:0]   sw_b
);
  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) sw_a[i] <= 1'b0;
        else     sw_a[i] <= cur_on && (cur_ch == ABITS'(i));
      end
    end
    if (DIFF) begin : g_pair
      assign sw_b = sw_a;
    end else begin : g_single
      assign sw_b = '0;
    end
  endgenerate
endmodule

// File: rtl/chsel_ctrl.sv
module chsel_ctrl #(
  parameter int SEL_W = 3,
  parameter bit DIFF  = 1'b0,
  parameter int DEAD  = 2,
  localparam int ABITS = DIFF ? SEL_W - 1 : SEL_W,
  localparam int NCH   = 1 << ABITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic             clr_n,
  input  logic [SEL_W-1:0] addr,
  input  logic             en,
  output logic [NCH-1:0]   sw_a,
  output logic [NCH-1:0]   sw_b,
  output logic [SEL_W-1:0] stat_ch,
  output logic             stat_en,
  output logic             busy
);
  localparam int BUS_W = SEL_W + 3;
  localparam logic [BUS_W-1:0] BUS_IDLE = {1'b1, 1'b1, {SEL_W{1'b0}}, 1'b0};

  logic [BUS_W-1:0] bus_s;
  logic             wr_n_s, clr_n_s, en_s;
  logic [SEL_W-1:0] addr_s;
  logic [ABITS-1:0] hold_ch, cur_ch;
  logic             hold_en, cur_on;

  ctl_sync #(.W(BUS_W), .IDLE(BUS_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({wr_n, clr_n, addr, en}),
    .q   (bus_s)
  );
  assign {wr_n_s, clr_n_s, addr_s, en_s} = bus_s;

  sel_latch #(.SEL_W(SEL_W), .ABITS(ABITS)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_n_s  (wr_n_s),
    .clr_n_s (clr_n_s),
    .addr_s  (addr_s),
    .en_s    (en_s),
    .hold_ch (hold_ch),
    .hold_en (hold_en)
  );

  bbm_seq #(.ABITS(ABITS), .DEAD(DEAD)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .tgt_on (hold_en),
    .tgt_ch (hold_ch),
    .cur_on (cur_on),
    .cur_ch (cur_ch),
    .busy   (busy)
  );

  sw_decode #(.ABITS(ABITS), .NCH(NCH), .DIFF(DIFF)) u_dec (
    .clk    (clk),
    .rst    (rst),
    .cur_on (cur_on),
    .cur_ch (cur_ch),
    .sw_a   (sw_a),
    .sw_b   (sw_b)
  );

  assign stat_ch = SEL_W'(hold_ch);
  assign stat_en = hold_en;
endmodule

// File: rtl/chsel_ctrl_chk.sv
module chsel_ctrl_chk #(
  parameter int SEL_W = 3,
  parameter bit DIFF  = 1'b0,
  parameter int NCH   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_n,
  input logic [NCH-1:0]   sw_a,
  input logic [NCH-1:0]   sw_b,
  input logic [SEL_W-1:0] stat_ch,
  input logic             stat_en,
  input logic             busy
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sw_a == '0 && !busy && !stat_en && stat_ch == '0));

  p_clear_empties_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!clr_n, 3) |-> (!stat_en && stat_ch == '0));

  p_one_closed_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sw_a));

  p_pair_side_r8: assert property (@(posedge clk) disable iff (rst)
    (DIFF ? (sw_b == sw_a) : (sw_b == '0)));

  p_no_direct_swap_r9: assert property (@(posedge clk) disable iff (rst)
    (sw_a != '0) |=> (sw_a == '0 || $stable(sw_a)));

  p_gap_open_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> (sw_a == '0));
endmodule

bind chsel_ctrl chsel_ctrl_chk #(.SEL_W(SEL_W), .DIFF(DIFF), .NCH(NCH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .clr_n   (clr_n),
  .sw_a    (sw_a),
  .sw_b    (sw_b),
  .stat_ch (stat_ch),
  .stat_en (stat_en),
  .busy    (busy)
);

// File: tb/test_chsel_ctrl.sv
module test_chsel_ctrl;
  localparam int CLK_P  = 10;
  localparam int DEAD   = 3;
  localparam int SETTLE = 10 + DEAD;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_n = 1'b1;
  logic       clr_n = 1'b1;
  logic [2:0] addr = '0;
  logic       en = 1'b0;

  logic [7:0] se_a, se_b;
  logic [3:0] df_a, df_b;
  logic [2:0] se_st, df_st;
  logic       se_en, df_en, se_busy, df_busy;

  int n_chk = 0;
  int n_bad = 0;

  logic       m_en = 1'b0;
  logic [2:0] m_ch = '0;

  always #(CLK_P/2) clk = ~clk;

  chsel_ctrl #(.SEL_W(3), .DIFF(1'b0), .DEAD(DEAD)) i_chsel_ctrl (
    .clk(clk), .rst(rst), .wr_n(wr_n), .clr_n(clr_n), .addr(addr), .en(en),
    .sw_a(se_a), .sw_b(se_b), .stat_ch(se_st), .stat_en(se_en), .busy(se_busy));

  chsel_ctrl #(.SEL_W(3), .DIFF(1'b1), .DEAD(DEAD)) i_chsel_ctrl_diff (
    .clk(clk), .rst(rst), .wr_n(wr_n), .clr_n(clr_n), .addr(addr), .en(en),
    .sw_a(df_a), .sw_b(df_b), .stat_ch(df_st), .stat_en(df_en), .busy(df_busy));

  function automatic logic [7:0] exp_a(bit diff, logic e, logic [2:0] c);
    if (!e) return 8'h00;
    return diff ? (8'h01 << c[1:0]) : (8'h01 << c);
  endfunction

  function automatic logic [2:0] exp_st(bit diff, logic [2:0] c);
    return diff ? {1'b0, c[1:0]} : c;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Break-before-make monitor on both instances (R9, R10)
  logic [7:0] prv[2], lnz[2];
  int run[2], gap_len[2], brun[2], busy_len[2];
  initial for (int d = 0; d < 2; d++) begin
    prv[d] = '0; lnz[d] = '0; run[d] = 0; gap_len[d] = -1; brun[d] = 0; busy_len[d] = -1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      for (int d = 0; d < 2; d++) begin
        logic [7:0] cur;
        logic       b;
        cur = (d == 0) ? se_a : {4'h0, df_a};
        b   = (d == 0) ? se_busy : df_busy;
        if (cur != 0 && prv[d] != 0 && cur != prv[d])
          chk(1'b0, "R9 direct swap", cur, prv[d]);
        if (cur != 0 && prv[d] == 0 && lnz[d] != 0 && cur != lnz[d]) begin
          chk(run[d] >= DEAD, "R9 gap length", run[d], DEAD);
          gap_len[d] = run[d];
        end
        if (cur == 0) run[d]++;
        else begin run[d] = 0; lnz[d] = cur; end
        if (b) brun[d]++;
        else if (brun[d] > 0) begin busy_len[d] = brun[d]; brun[d] = 0; end
        prv[d] = cur;
      end
    end
  end

  task automatic check_all(string req);
    @(negedge clk);
    chk(se_a == exp_a(0, m_en, m_ch), req, se_a, exp_a(0, m_en, m_ch));
    chk(se_b == 8'h00, {req, " R7 b side"}, se_b, 0);
    chk(se_st == exp_st(0, m_ch) && se_en == m_en, {req, " status"}, {se_en, se_st}, {m_en, exp_st(0, m_ch)});
    chk({4'h0, df_a} == exp_a(1, m_en, m_ch), {req, " R8 diff a"}, df_a, exp_a(1, m_en, m_ch));
    chk(df_b == df_a, {req, " R8 diff b"}, df_b, df_a);
    chk(df_st == exp_st(1, m_ch) && df_en == m_en, {req, " R8 status"}, {df_en, df_st}, {m_en, exp_st(1, m_ch)});
    chk(!se_busy && !df_busy, {req, " idle busy"}, {se_busy, df_busy}, 0);
    tick(1);
  endtask

  task automatic do_write(logic [2:0] a, logic e);
    addr = a; en = e;
    tick(1);
    wr_n = 1'b0;
    tick(3);
    wr_n = 1'b1;
    tick(1);
    m_en = e; m_ch = a;
    tick(SETTLE);
  endtask

  initial begin
    #(CLK_P * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h0C5E_1A7D);
    tick(4);
    check_all("R1 in reset");
    rst = 1'b0;
    tick(1);
    check_all("R1 after reset");

    // R7, R8: first selection
    do_write(3'd5, 1'b1);
    check_all("R7 code 5");

    // R3: bus moves while strobe is high
    addr = 3'd2; en = 1'b0;
    tick(SETTLE);
    check_all("R3 ignored change");

    // R9, R10: hand-over with exact gap
    do_write(3'd2, 1'b1);
    check_all("R9 handover");
    chk(gap_len[0] == DEAD, "R9 exact gap se", gap_len[0], DEAD);
    chk(gap_len[1] == DEAD, "R9 exact gap diff", gap_len[1], DEAD);
    chk(busy_len[0] == DEAD, "R10 busy width se", busy_len[0], DEAD);
    chk(busy_len[1] == DEAD, "R10 busy width diff", busy_len[1], DEAD);

    // R8: top bit does not matter in the pair layout
    do_write(3'd6, 1'b1);
    check_all("R8 top bit set");

    // R6: enable 0 opens everything
    do_write(3'd7, 1'b0);
    check_all("R6 disabled");

    // R2: transparent run
    wr_n = 1'b0;
    addr = 3'd3; en = 1'b1; m_ch = 3'd3; m_en = 1'b1;
    tick(SETTLE);
    check_all("R2 follow 3");
    addr = 3'd4; m_ch = 3'd4;
    tick(SETTLE);
    check_all("R2 follow 4");

    // R4: clear wins while strobe is low
    clr_n = 1'b0;
    addr = 3'd1;
    m_en = 1'b0; m_ch = 3'd0;
    tick(SETTLE);
    check_all("R4 clear during write");
    clr_n = 1'b1; wr_n = 1'b1;
    tick(SETTLE);
    check_all("R5 off after clear");
    addr = 3'd0; en = 1'b1;
    tick(SETTLE);
    check_all("R5 still off");
    do_write(3'd1, 1'b1);
    check_all("R5 write reopens");

    // Random mix
    for (int it = 0; it < 150; it++) begin
      int op;
      logic [2:0] a;
      logic e;
      op = int'($urandom % 4);
      a  = 3'($urandom);
      e  = 1'($urandom);
      case (op)
        0: begin do_write(a, e); check_all("R7 random write"); end
        1: begin addr = a; en = e; tick(SETTLE); check_all("R3 random ignore"); end
        2: begin
          clr_n = 1'b0; wr_n = 1'($urandom); addr = a; en = e;
          m_en = 1'b0; m_ch = 3'd0;
          tick(6);
          clr_n = 1'b1; wr_n = 1'b1;
          tick(SETTLE);
          check_all("R4 random clear");
        end
        default: begin
          wr_n = 1'b0; addr = a; en = e; m_ch = a; m_en = e;
          tick(SETTLE);
          check_all("R2 random follow");
          wr_n = 1'b1;
          tick(2);
        end
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule